// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of one-bit ownership tokens that two agents, the left port and the right port, use to claim shared resources. The tokens live apart from any memory array. A port reaches the token space by raising its semaphore-select while its memory enable is low. The low address bits pick a token. Bit 0 of the write data either asks for the token (0) or gives it back (1).

Each port sees the token from its own side. A port that holds a token reads zeros, and every other case reads ones. A request from the port that does not hold the token is not lost: it is kept as a waiting claim, and the token passes to that port on the same edge at which the holder gives it up. Same-cycle claims on a free token are settled in favour of the left port, and the right port's claim is then kept as a waiting claim. Read results are registered and held until the next read from the same port.

Top module: `tokbank_top`

## Requirements
- R1: After reset every token is free, no claim is waiting, and both read-data registers hold all ones.
- R2: A port's operation takes effect only when its semaphore-select is 1 and its memory enable is 0. Otherwise its write leaves all tokens unchanged and its read leaves its read data unchanged.
- R3: The token index is the low log2(NUM_SEM) address bits (bits 2:0 by default). All higher address bits have no effect.
- R4: Only write-data bit 0 is used. 0 requests the token and 1 releases it. All other data bits have no effect.
- R5: When one port requests a free token, that port afterwards reads all zeros at that index and the other port reads all ones.
- R6: While one port holds a token, writes from the other port never change who holds it.
- R7: A 0 written by the non-holder is kept as a waiting claim. When the holder writes 1, the token passes directly to the waiting port on that same edge.
- R8: A release by the holder with no waiting claim makes the token free, and both ports then read all ones.
- R9: When both ports request the same free token in the same cycle, the left port gets it and the right port's request becomes a waiting claim.
- R10: A waiting claim is withdrawn when the waiting port writes 1 before it is granted. A later release by the holder then frees the token.
- R11: A read loads every data bit with the port's view (0 = this port holds the token, 1 = it does not). The result appears one cycle later and is held until that port's next read, whatever the other port does in between.
- R12: A read and a write in the same cycle return the token state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_sel | input | 1 | Left port token-space select |
| l_mem_en | input | 1 | Left port memory enable (blocks token access when 1) |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port registered read data |
| r_sem_sel | input | 1 | Right port token-space select |
| r_mem_en | input | 1 | Right port memory enable (blocks token access when 1) |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port registered read data |

## Verification
A write changes the token state at the clock edge that samples it, so a read issued in the next cycle already sees the new holder. A read loads its register at the edge that samples it, so its value is valid from just after that edge until the port's next read. The bench drives each operation for one cycle and advances its behavioural model at that same edge. It compares both read-data outputs against the model at the falling edge that follows, on every cycle. Because the model keeps the held values, the R11 hold and the R12 pre-write order are checked on every compare, not only where a scenario aims at them.

// File: rtl/tokbank_pkg.sv
package tokbank_pkg;
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } holder_e;
endpackage

// File: rtl/tokbank_port_dec.sv
module tokbank_port_dec #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               sem_sel,
  input  logic               mem_en,
  input  logic               wr,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SEM-1:0] req_v,
  output logic [NUM_SEM-1:0] rel_v,
  output logic               rd_en,
  output logic [IDX_W-1:0]   rd_idx
);
  logic             go;
  logic [IDX_W-1:0] idx;
  logic             unused_bits;

  assign go          = sem_sel & ~mem_en;
  assign idx         = addr[IDX_W-1:0];
  assign rd_en       = go & rd;
  assign rd_idx      = idx;
  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sel
    assign req_v[i] = go & wr & ~wdata[0] & (idx == IDX_W'(i));
    assign rel_v[i] = go & wr &  wdata[0] & (idx == IDX_W'(i));
  end
endmodule

// File: rtl/tokbank_cell.sv
module tokbank_cell
  import tokbank_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    l_req,
  input  logic    l_rel,
  input  logic    r_req,
  input  logic    r_rel,
  output holder_e holder_q,
  output logic    wait_q
);
  holder_e holder_d;
  logic    wait_d;

  always_comb begin
    holder_d = holder_q;
    wait_d   = wait_q;
    case (holder_q)
      HOLD_NONE: begin
        if (l_req) begin
          holder_d = HOLD_LEFT;
          wait_d   = r_req;
        end else if (r_req) begin
          holder_d = HOLD_RIGHT;
        end
      end
      HOLD_LEFT: begin
        if (r_req)      wait_d = 1'b1;
        else if (r_rel) wait_d = 1'b0;
        if (l_rel) begin
          holder_d = wait_d ? HOLD_RIGHT : HOLD_NONE;
          wait_d   = 1'b0;
        end
      end
      HOLD_RIGHT: begin
        if (l_req)      wait_d = 1'b1;
        else if (l_rel) wait_d = 1'b0;
        if (r_rel) begin
          holder_d = wait_d ? HOLD_LEFT : HOLD_NONE;
          wait_d   = 1'b0;
        end
      end
      default: begin
        holder_d = HOLD_NONE;
        wait_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holder_q <= HOLD_NONE;
      wait_q   <= 1'b0;
    end else begin
      holder_q <= holder_d;
      wait_q   <= wait_d;
    end
  end
endmodule

// File: rtl/tokbank_readout.sv
module tokbank_readout #(
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  input  logic [NUM_SEM-1:0] not_mine,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) rdata_d = {DATA_W{not_mine[rd_idx]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '1;
    else        rdata_q <= rdata_d;
  end
endmodule

// File: rtl/tokbank_top.sv
module tokbank_top
  import tokbank_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_sel,
  input  logic              l_mem_en,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_sel,
  input  logic              r_mem_en,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_SEM-1:0]   l_req, l_rel, r_req, r_rel;
  logic                 l_rd_en, r_rd_en;
  logic [IDX_W-1:0]     l_rd_idx, r_rd_idx;
  logic [NUM_SEM-1:0]   l_not_mine, r_not_mine;
  logic [NUM_SEM-1:0]   wait_v;
  logic [2*NUM_SEM-1:0] state_flat;
  holder_e              holder_v [NUM_SEM];

  tokbank_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_l (
    .sem_sel(l_sem_sel), .mem_en(l_mem_en), .wr(l_wr), .rd(l_rd),
    .addr(l_addr), .wdata(l_wdata), .req_v(l_req), .rel_v(l_rel),
    .rd_en(l_rd_en), .rd_idx(l_rd_idx)
  );

  tokbank_port_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_r (
    .sem_sel(r_sem_sel), .mem_en(r_mem_en), .wr(r_wr), .rd(r_rd),
    .addr(r_addr), .wdata(r_wdata), .req_v(r_req), .rel_v(r_rel),
    .rd_en(r_rd_en), .rd_idx(r_rd_idx)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    tokbank_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .l_req(l_req[i]), .l_rel(l_rel[i]),
      .r_req(r_req[i]), .r_rel(r_rel[i]),
      .holder_q(holder_v[i]), .wait_q(wait_v[i])
    );
    assign l_not_mine[i]         = (holder_v[i] != HOLD_LEFT);
    assign r_not_mine[i]         = (holder_v[i] != HOLD_RIGHT);
    assign state_flat[2*i +: 2]  = holder_v[i];
  end

  tokbank_readout #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_out_l (
    .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en), .rd_idx(l_rd_idx),
    .not_mine(l_not_mine), .rdata_q(l_rdata)
  );

  tokbank_readout #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_out_r (
    .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en), .rd_idx(r_rd_idx),
    .not_mine(r_not_mine), .rdata_q(r_rdata)
  );

  logic unused_wait;
  assign unused_wait = ^wait_v;
endmodule

// File: rtl/tokbank_chk.sv
module tokbank_chk #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 8,
  parameter int NUM_SEM = 8,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 l_sem_sel,
  input logic                 l_mem_en,
  input logic                 l_wr,
  input logic                 l_rd,
  input logic [ADDR_W-1:0]    l_addr,
  input logic [DATA_W-1:0]    l_wdata,
  input logic [DATA_W-1:0]    l_rdata,
  input logic                 r_sem_sel,
  input logic                 r_mem_en,
  input logic                 r_wr,
  input logic                 r_rd,
  input logic [ADDR_W-1:0]    r_addr,
  input logic [DATA_W-1:0]    r_wdata,
  input logic [DATA_W-1:0]    r_rdata,
  input logic [2*NUM_SEM-1:0] state_flat
);
  logic             l_go, r_go, tie;
  logic [IDX_W-1:0] l_idx, r_idx, tie_idx_q;

  assign l_go  = l_sem_sel & ~l_mem_en;
  assign r_go  = r_sem_sel & ~r_mem_en;
  assign l_idx = l_addr[IDX_W-1:0];
  assign r_idx = r_addr[IDX_W-1:0];
  assign tie   = l_go && l_wr && !l_wdata[0] && r_go && r_wr && !r_wdata[0]
                 && (l_idx == r_idx) && (state_flat[2*l_idx +: 2] == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tie_idx_q <= '0;
    else        tie_idx_q <= l_idx;
  end

  p_reset_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (state_flat == '0));

  p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(l_go && l_wr) && !(r_go && r_wr)) |=> $stable(state_flat));

  p_mutex_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_go && l_rd && r_go && r_rd && (l_idx == r_idx))
      |=> !((l_rdata == '0) && (r_rdata == '0)));

  p_tie_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tie |=> (state_flat[2*tie_idx_q +: 2] == 2'd1));

  p_hold_left_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_go && l_rd) |=> $stable(l_rdata));

  p_hold_right_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_go && r_rd) |=> $stable(r_rdata));

  p_uniform_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_rdata == '0) || (l_rdata == '1)) && ((r_rdata == '0) || (r_rdata == '1)));

  logic unused_hi;
  assign unused_hi = ^{l_addr, r_addr, l_wdata, r_wdata};
endmodule

bind tokbank_top tokbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_rd(l_rd),
  .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
  .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_rd(r_rd),
  .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
  .state_flat(state_flat)
);

// File: tb/tokbank_top_test.sv
module tokbank_top_test;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          l_sem_sel, l_mem_en, l_wr, l_rd, r_sem_sel, r_mem_en, r_wr, r_rd;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  int            checks = 0;
  int            fails  = 0;
  string         tag    = "R1";

  int            own [NS];
  bit            wt  [NS];
  logic [DW-1:0] exp_l, exp_r;

  always #2.5 clk = ~clk;

  tokbank_top uut (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_rd(l_rd),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_rd(r_rd),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic idle();
    l_sem_sel = 0; l_mem_en = 0; l_wr = 0; l_rd = 0; l_addr = '0; l_wdata = '0;
    r_sem_sel = 0; r_mem_en = 0; r_wr = 0; r_rd = 0; r_addr = '0; r_wdata = '0;
  endtask

  task automatic set_l(logic sel, logic mem, logic w, logic r, logic [AW-1:0] a, logic [DW-1:0] d);
    l_sem_sel = sel; l_mem_en = mem; l_wr = w; l_rd = r; l_addr = a; l_wdata = d;
  endtask

  task automatic set_r(logic sel, logic mem, logic w, logic r, logic [AW-1:0] a, logic [DW-1:0] d);
    r_sem_sel = sel; r_mem_en = mem; r_wr = w; r_rd = r; r_addr = a; r_wdata = d;
  endtask

  // behavioural reference: 0 free, 1 left holds, 2 right holds
  task automatic model_edge();
    bit lg = l_sem_sel && !l_mem_en;
    bit rg = r_sem_sel && !r_mem_en;
    int li = int'(l_addr) % NS;
    int ri = int'(r_addr) % NS;
    if (lg && l_rd) exp_l = (own[li] == 1) ? '0 : '1;
    if (rg && r_rd) exp_r = (own[ri] == 2) ? '0 : '1;
    for (int k = 0; k < NS; k++) begin
      bit lw  = lg && l_wr && (li == k);
      bit rw  = rg && r_wr && (ri == k);
      bit lq  = lw && !l_wdata[0];
      bit lr  = lw &&  l_wdata[0];
      bit rq  = rw && !r_wdata[0];
      bit rr  = rw &&  r_wdata[0];
      if (own[k] == 0) begin
        if (lq) begin own[k] = 1; wt[k] = rq; end
        else if (rq) own[k] = 2;
      end else if (own[k] == 1) begin
        if (rq) wt[k] = 1; else if (rr) wt[k] = 0;
        if (lr) begin own[k] = wt[k] ? 2 : 0; wt[k] = 0; end
      end else begin
        if (lq) wt[k] = 1; else if (lr) wt[k] = 0;
        if (rr) begin own[k] = wt[k] ? 1 : 0; wt[k] = 0; end
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (l_rdata !== exp_l) begin
      fails++;
      $display("FAIL %s left rdata: actual=%h expected=%h", tag, l_rdata, exp_l);
    end
    checks++;
    if (r_rdata !== exp_r) begin
      fails++;
      $display("FAIL %s right rdata: actual=%h expected=%h", tag, r_rdata, exp_r);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic rd_both(int idx);
    set_l(1, 0, 0, 1, AW'(idx), '0);
    set_r(1, 0, 0, 1, AW'(idx), '0);
    tick();
  endtask

  initial begin
    idle();
    for (int k = 0; k < NS; k++) begin own[k] = 0; wt[k] = 0; end
    exp_l = '1; exp_r = '1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; compare();
    for (int k = 0; k < NS; k++) rd_both(k);

    // R5 left claims free token 3
    tag = "R5"; set_l(1, 0, 1, 0, 12'd3, 8'h00); tick(); rd_both(3);
    // R6 right release/claim attempts while left holds
    tag = "R6"; set_r(1, 0, 1, 0, 12'd3, 8'h01); tick(); rd_both(3);
    set_r(1, 0, 1, 0, 12'd3, 8'h00); tick(); rd_both(3);
    set_l(1, 0, 1, 0, 12'd3, 8'h00); tick(); rd_both(3);
    // R7 holder releases, waiting right gets it
    tag = "R7"; set_l(1, 0, 1, 0, 12'd3, 8'h01); tick(); rd_both(3);
    // R8 right releases with nobody waiting
    tag = "R8"; set_r(1, 0, 1, 0, 12'd3, 8'h01); tick(); rd_both(3);

    // R9 tie on token 5
    tag = "R9";
    set_l(1, 0, 1, 0, 12'd5, 8'h00); set_r(1, 0, 1, 0, 12'd5, 8'h00); tick(); rd_both(5);
    set_l(1, 0, 1, 0, 12'd5, 8'h01); tick(); rd_both(5);
    set_r(1, 0, 1, 0, 12'd5, 8'h01); tick(); rd_both(5);

    // R10 withdraw waiting claim
    tag = "R10";
    set_r(1, 0, 1, 0, 12'd6, 8'h00); tick();
    set_l(1, 0, 1, 0, 12'd6, 8'h00); tick();
    set_l(1, 0, 1, 0, 12'd6, 8'h01); tick(); rd_both(6);
    set_r(1, 0, 1, 0, 12'd6, 8'h01); tick(); rd_both(6);

    // R2 blocked accesses
    tag = "R2";
    set_l(1, 1, 1, 0, 12'd1, 8'h00); tick(); rd_both(1);
    set_r(0, 0, 1, 0, 12'd1, 8'h00); tick(); rd_both(1);
    set_l(1, 0, 1, 0, 12'd1, 8'h00); tick();
    set_l(1, 1, 0, 1, 12'd2, 8'h00); set_r(0, 0, 0, 1, 12'd1, 8'h00); tick();
    rd_both(1);
    set_l(1, 0, 1, 0, 12'd1, 8'h01); tick();

    // R3 high address bits ignored
    tag = "R3";
    set_l(1, 0, 1, 0, 12'hA42, 8'h00); tick();
    set_l(1, 0, 0, 1, 12'h002, 8'h00); set_r(1, 0, 0, 1, 12'hFFA, 8'h00); tick();
    set_r(1, 0, 1, 0, 12'h7F2, 8'h00); tick();
    set_l(1, 0, 1, 0, 12'h5D2, 8'h01); tick(); rd_both(2);

    // R4 only data bit 0 matters
    tag = "R4";
    set_r(1, 0, 1, 0, 12'd2, 8'hFF); tick(); rd_both(2);
    set_l(1, 0, 1, 0, 12'd4, 8'hFE); tick(); rd_both(4);
    set_l(1, 0, 1, 0, 12'd4, 8'h81); tick(); rd_both(4);

    // R11 held read value while the other side changes state
    tag = "R11";
    set_l(1, 0, 0, 1, 12'd7, 8'h00); tick();
    set_r(1, 0, 1, 0, 12'd7, 8'h00); tick();
    tick();
    set_r(1, 0, 1, 0, 12'd7, 8'h01); tick();

    // R12 read and write in the same cycle
    tag = "R12";
    set_l(1, 0, 1, 1, 12'd0, 8'h00); tick();
    set_l(1, 0, 1, 1, 12'd0, 8'h01); tick();
    rd_both(0);

    summary();
    $finish;
  end
endmodule